// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a single 32-bit memory-mapped status and control word. It records which reset sources have fired since the record was last cleared. There are six sticky cause flags, one per reset source. The word also holds a write-1 clear-all control, an enable for a low-speed oscillator, and a read-only ready indication for that oscillator. Each cause arrives as a one-cycle pulse on `evt_i`. Firmware reads the word after boot to learn why the chip restarted, then clears the record.

The block has two reset domains. `por_n` is the power reset and returns every bit to its initial state, including the cause record. `sys_rst_n` is the system reset and returns only the oscillator enable, the oscillator model and the bus state machine, so the cause record survives it. The oscillator is modelled as a three-state machine (OFF, START, RUN) with a fixed start-up delay.

Bus access uses a four-state machine:
- IDLE: no access completed last cycle. A request completes in the same cycle and moves to RECENT.
- RECENT: an access completed last cycle. A new request is stalled and moves to STALL1. With no request the machine returns to IDLE.
- STALL1: the request is held and the machine moves to STALL2.
- STALL2: the access completes and the machine moves to RECENT.

In STALL1 or STALL2, a dropped request returns the machine to IDLE. The requester must hold `req_i`, `we_i`, `addr_i`, `wdata_i` and `be_i` steady until `ready_o` is high.

Top module: `rstcause_reg`

## Requirements
- R1: The word answers only at byte address 0x24 (`addr_i` compared in full). An access to any other address completes with `rdata_o` = 0 and changes nothing.
- R2: After `por_n` is released, the word reads 0x0C000000. Flags at bits 27 and 26 are 1, and every other bit is 0.
- R3: A pulse on `evt_i[k]` sets the flag at bit 26+k, and the flag then stays 1 until it is cleared. The mapping is: k=0 external pin, 1 power-on/power-down, 2 software, 3 independent watchdog, 4 window watchdog, 5 low-power.
- R4: A completed write with `be_i[3]`=1 and `wdata_i[24]`=1 clears all six flags on the next edge. Writing 0 to bit 24, or writing with `be_i[3]`=0, has no effect. Bit 24 always reads 0.
- R5: If a cause pulse arrives in the same cycle as a clear-all write, that cause's flag is 1 afterwards.
- R6: A system reset clears the oscillator enable and the ready bit but leaves all six flags unchanged.
- R7: Bit 0 is the oscillator enable. It is written only when `be_i[0]`=1 and reads back the written value.
- R8: Bit 1 (oscillator ready) reads 1 from the 8th cycle after the edge that sets the enable. It reads 0 again from the cycle after the enable is cleared.
- R9: Bits 25 and 23 to 2 read 0, and bus writes never change the flags except through R4.
- R10: `ready_o` follows `req_i` in the same cycle (0 wait states) unless an access completed in the previous cycle. In that case the access gets exactly 2 wait states. `rdata_o` is the word's value while `req_i` and `ready_o` are high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power reset, active low, asynchronous; resets everything |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; spares the cause flags |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte lane strobes |
| evt_i | input | 6 | One-cycle cause pulses (mapping in R3) |
| rdata_o | output | 32 | Read data, valid with ready |
| ready_o | output | 1 | Access completes this cycle |

## Verification
Some situations can only be reached through exact timing. These are a cause pulse landing in the very cycle a clear-all write completes, and the ready bit on either side of its eighth cycle. The bench reaches the first by driving the pulse together with an isolated write, which completes in its first cycle. It reaches the second by placing single idle-separated reads exactly 7 and 8 cycles after the enabling edge. Back-to-back chains, including a disable followed at once by a read, exercise the stall path. A behavioural model checks every cycle in between.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;
    localparam int N_CAUSE  = 6;
    localparam int FLAG_LSB = 26;
    localparam int CLR_BIT  = 24;
    localparam int RDY_BIT  = 1;
    localparam int EN_BIT   = 0;
    localparam logic [N_CAUSE-1:0] FLAGS_AT_POR = 6'b000011;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_RECENT,
        BUS_STALL1,
        BUS_STALL2
    } bus_st_e;

    typedef enum logic [1:0] {
        OSC_OFF,
        OSC_START,
        OSC_RUN
    } osc_st_e;
endpackage

// File: rtl/rstcause_bus.sv
module rstcause_bus
    import rstcause_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic ready_o
);
    bus_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = BUS_IDLE;
        unique case (state_q)
            BUS_IDLE:   state_d = req_i ? BUS_RECENT : BUS_IDLE;
            BUS_RECENT: state_d = req_i ? BUS_STALL1 : BUS_IDLE;
            BUS_STALL1: state_d = req_i ? BUS_STALL2 : BUS_IDLE;
            BUS_STALL2: state_d = req_i ? BUS_RECENT : BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        ready_o = 1'b0;
        unique case (state_q)
            BUS_IDLE, BUS_STALL2:   ready_o = req_i;
            BUS_RECENT, BUS_STALL1: ready_o = 1'b0;
            default:                ready_o = 1'b0;
        endcase
    end

    // R10: a completed access is never followed by a completion in the next cycle
    a_r10_b2b_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ready_o) |=> !ready_o);
    // R10: a fresh request after an idle cycle completes at once
    a_r10_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !$past(req_i)) |-> ready_o);
endmodule

// File: rtl/rstcause_osc.sv
module rstcause_osc
    import rstcause_pkg::*;
#(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic rdy_o
);
    localparam int CNT_W = $clog2(DLY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DLY - 1);

    osc_st_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OSC_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            OSC_OFF: begin
                cnt_d = '0;
                if (en_i) begin
                    state_d = OSC_START;
                    cnt_d   = CNT_W'(1);
                end
            end
            OSC_START: begin
                if (!en_i) begin
                    state_d = OSC_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = OSC_RUN;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            OSC_RUN: begin
                if (!en_i) begin
                    state_d = OSC_OFF;
                    cnt_d   = '0;
                end
            end
            default: state_d = OSC_OFF;
        endcase
    end

    always_comb rdy_o = (state_q == OSC_RUN);

    // R8: ready only after the enable was seen in the previous cycle
    a_r8_rdy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> $past(en_i));
    // R8: two cycles of disabled enable leave ready low
    a_r8_rdy_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !$past(en_i)) |-> !rdy_o);
endmodule

// File: rtl/rstcause_flags.sv
module rstcause_flags
    import rstcause_pkg::*;
#(
    parameter int N = N_CAUSE,
    parameter logic [N-1:0] INIT = FLAGS_AT_POR
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)        flag_q[i] <= INIT[i];
            else if (evt_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i)    flag_q[i] <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    // R3: without a clear, no flag falls
    a_r3_sticky: assert property (@(posedge clk) disable iff (!por_n)
        !clr_i |=> (($past(flag_q) & ~flag_q) == '0));
    // R5: a pulse sets its flag even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!por_n)
        (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
    // R4: a clear with no pulse empties the record
    a_r4_clear_all: assert property (@(posedge clk) disable iff (!por_n)
        (clr_i && evt_i == '0) |=> (flag_q == '0));
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
    import rstcause_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFF = 8'h24,
    parameter int                OSC_DLY = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [N_CAUSE-1:0] evt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ready_o
);
    localparam int CLR_LANE = CLR_BIT / 8;
    localparam int EN_LANE  = EN_BIT / 8;

    logic               rst_n;
    logic               hit, xfer, wr_hit, clr;
    logic               en_q, osc_rdy;
    logic [N_CAUSE-1:0] flags;
    logic [DATA_W-1:0]  rd_word;
    logic               unused_in;

    assign rst_n  = por_n & sys_rst_n;
    assign hit    = (addr_i == REG_OFF);
    assign xfer   = req_i & ready_o;
    assign wr_hit = xfer & we_i & hit;
    assign clr    = wr_hit & be_i[CLR_LANE] & wdata_i[CLR_BIT];
    assign unused_in = ^{wdata_i[DATA_W-1:CLR_BIT+1], wdata_i[CLR_BIT-1:EN_BIT+1],
                         be_i[CLR_LANE-1:EN_LANE+1]};

    rstcause_bus u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .ready_o (ready_o)
    );

    rstcause_flags #(.N(N_CAUSE), .INIT(FLAGS_AT_POR)) u_flags (
        .clk    (clk),
        .por_n  (por_n),
        .evt_i  (evt_i),
        .clr_i  (clr),
        .flag_o (flags)
    );

    rstcause_osc #(.DLY(OSC_DLY)) u_osc (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_q),
        .rdy_o (osc_rdy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      en_q <= 1'b0;
        else if (wr_hit && be_i[EN_LANE]) en_q <= wdata_i[EN_BIT];
    end

    always_comb begin
        rd_word                        = '0;
        rd_word[FLAG_LSB +: N_CAUSE]   = flags;
        rd_word[RDY_BIT]               = osc_rdy;
        rd_word[EN_BIT]                = en_q;
        rdata_o = (xfer && hit) ? rd_word : '0;
    end

    // R4: the clear control never reads back as 1
    a_r4_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !rdata_o[CLR_BIT]);
    // R1: a miss returns zero data
    a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && addr_i != REG_OFF) |-> (rdata_o == '0));
endmodule

// File: tb/rstcause_reg_test.sv
module rstcause_reg_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [5:0]  evt = '0;
    logic [31:0] rdata;
    logic        ready;

    always #4 clk = ~clk;

    rstcause_reg uut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .req_i(req), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .be_i(be), .evt_i(evt),
        .rdata_o(rdata), .ready_o(ready)
    );

    int    checks = 0, fails = 0;
    string tag = "R2";

    logic [5:0] m_flags = 6'b000011;
    bit  m_en = 0, m_last = 0;
    int  m_cnt = 0, m_pend = 0, m_need = 0;

    task automatic m_sys();
        m_en = 0; m_cnt = 0; m_last = 0; m_pend = 0; m_need = 0;
    endtask

    function automatic int need_now();
        return (m_pend == 0) ? (m_last ? 2 : 0) : m_need;
    endfunction

    function automatic bit exp_ready();
        return req && (m_pend == need_now());
    endfunction

    function automatic bit hit_now();
        return addr == 8'h24;
    endfunction

    function automatic logic [31:0] m_word();
        logic [31:0] w = '0;
        w[31:26] = m_flags;
        w[1] = (m_cnt == 8);
        w[0] = m_en;
        return w;
    endfunction

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        if (!por_n) begin
            m_flags = 6'b000011; m_sys();
        end else if (!sys_rst_n) begin
            m_sys();
        end else begin
            bit rdy_b, wr_b;
            int nd;
            rdy_b = exp_ready();
            nd    = need_now();
            wr_b  = rdy_b && we && hit_now();
            if (m_en) begin
                if (m_cnt < 8) m_cnt++;
            end else m_cnt = 0;
            if (wr_b && be[3] && wdata[24]) m_flags = '0;
            m_flags = m_flags | evt;
            if (wr_b && be[0]) m_en = wdata[0];
            if (rdy_b) begin
                m_last = 1; m_pend = 0;
            end else if (req) begin
                if (m_pend == 0) m_need = nd;
                m_pend++; m_last = 0;
            end else begin
                m_last = 0; m_pend = 0;
            end
        end
    end

    // per-cycle comparison, away from the edge
    always begin
        @(negedge clk);
        #2;
        if (!por_n) begin m_flags = 6'b000011; m_sys(); end
        else if (!sys_rst_n) m_sys();
        check({tag, " ready"}, {31'b0, ready}, {31'b0, exp_ready()});
        check({tag, " rdata"}, rdata, (exp_ready() && hit_now()) ? m_word() : 32'h0);
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); req = 0; we = 0; evt = '0;
        end
    endtask

    task automatic bus(input bit w, input logic [7:0] a, input logic [31:0] d,
                       input logic [3:0] b, input logic [5:0] ev,
                       output logic [31:0] rd, output int waits);
        bit done;
        waits = 0;
        @(negedge clk);
        req = 1; we = w; addr = a; wdata = d; be = b; evt = ev;
        forever begin
            #1; done = ready; rd = rdata;
            @(posedge clk);
            if (done) break;
            @(negedge clk); evt = '0; waits++;
        end
    endtask

    task automatic rd24(output logic [31:0] rd, output int waits);
        bus(0, 8'h24, 32'h0, 4'hF, 6'h0, rd, waits);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
        logic [31:0] rd;
        int w;
        bus(1, a, d, b, 6'h0, rd, w);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int w;
        repeat (3) @(negedge clk);
        por_n = 1;
        @(negedge clk); sys_rst_n = 1;
        idle(2);

        tag = "R2"; rd24(rd, w);
        check("R2 power-up value", rd, 32'h0C00_0000);
        check("R10 isolated waits", w, 0);
        tag = "R10"; rd24(rd, w);
        check("R10 back-to-back waits", w, 2);
        check("R10 back-to-back data", rd, 32'h0C00_0000);

        idle(1); tag = "R4"; wr(8'h24, 32'h0100_0000, 4'b1000);
        idle(1); rd24(rd, w);
        check("R4 clear-all", rd, 32'h0);

        tag = "R3";
        for (int i = 0; i < 6; i++) begin
            idle(1);
            @(negedge clk); req = 0; evt = 6'(1 << i);
            idle(1); rd24(rd, w);
            check("R3 cause flag", rd, 32'((64'(1) << (i + 1)) - 1) << 26);
        end

        tag = "R4"; idle(1);
        wr(8'h24, 32'h0, 4'b1000);
        idle(1); wr(8'h24, 32'h0100_0000, 4'b0111);
        idle(1); rd24(rd, w);
        check("R4 no-effect writes", rd, 32'hFC00_0000);

        tag = "R9"; idle(1); wr(8'h24, 32'hFEFF_FFFE, 4'hF);
        idle(1); rd24(rd, w);
        check("R9 reserved and flags untouched", rd, 32'hFC00_0000);

        tag = "R5"; idle(1);
        bus(1, 8'h24, 32'h0100_0000, 4'b1000, 6'b010000, rd, w);
        check("R5 clear write isolated", w, 0);
        idle(1); rd24(rd, w);
        check("R5 set wins", rd, 32'h4000_0000);

        tag = "R1"; idle(1); wr(8'h20, 32'h0100_0001, 4'hF);
        idle(1); bus(0, 8'h28, 32'h0, 4'hF, 6'h0, rd, w);
        check("R1 other address reads 0", rd, 32'h0);
        idle(1); rd24(rd, w);
        check("R1 other address wrote nothing", rd, 32'h4000_0000);

        tag = "R7"; idle(1); wr(8'h24, 32'h1, 4'b1110);
        idle(1); rd24(rd, w);
        check("R7 lane 0 off", rd, 32'h4000_0000);
        idle(1); wr(8'h24, 32'h1, 4'b0001);
        tag = "R8"; idle(7); rd24(rd, w);
        check("R8 not ready at cycle 7", rd, 32'h4000_0001);
        rd24(rd, w);
        check("R8 ready later", rd, 32'h4000_0003);
        wr(8'h24, 32'h0, 4'b0001);
        rd24(rd, w);
        check("R8 ready falls", rd, 32'h4000_0000);
        idle(2); wr(8'h24, 32'h1, 4'b0001);
        idle(8); rd24(rd, w);
        check("R8 ready at cycle 8", rd, 32'h4000_0003);

        tag = "R6"; idle(1);
        @(negedge clk); sys_rst_n = 0;
        idle(2);
        @(negedge clk); sys_rst_n = 1;
        idle(1); rd24(rd, w);
        check("R6 flags survive system reset", rd, 32'h4000_0000);

        tag = "R2"; idle(1);
        @(negedge clk); por_n = 0;
        idle(2);
        @(negedge clk); por_n = 1;
        idle(1); rd24(rd, w);
        check("R2 power reset again", rd, 32'h0C00_0000);

        idle(2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule